// File: doc/BRIEF.md
# ATM Cell Header Check Byte Generator

This block computes the 8-bit header check byte of an ATM cell. The four leading header bytes arrive on a byte bus, one per accepted cycle. A start flag marks the first byte of each header. Cycles where the byte-valid input is low are skipped. The block keeps a running CRC-8 remainder with feedback constant 0x07. The remainder starts from zero, and bytes are folded in most significant byte first. After the fourth byte, the remainder is XORed with 0x55, and the result is driven with a one-cycle done strobe.

An optional check mode verifies a received check byte. When the mode input is high as the fourth byte is taken, the next valid byte without a start flag is treated as the received check byte. If it differs from the computed value, a one-cycle mismatch strobe is raised. A build parameter selects how each per-byte step is computed: a 256-entry lookup table filled at elaboration, or an unrolled eight-step shift. Both give identical results.

Top module: `hcs_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hec_done` and `hec_mismatch` are 0 and `hec_byte` is 0x00.
- R2: The output equals the CRC-8 of the four header bytes, with polynomial x^8+x^2+x+1 (feedback 0x07) and initial remainder 0x00. The first byte accepted is the most significant, and the final remainder is XORed with 0x55. For example, 00 00 00 00 gives 0x55 and 00 00 00 01 gives 0x52.
- R3: `hec_done` is high for exactly one cycle: the cycle after the clock edge that accepts the fourth header byte.
- R4: Cycles with `hdr_valid` low do not change the remainder or the byte count, so gaps between header bytes do not alter the result.
- R5: A valid byte with `hdr_start` high always begins a new header, discarding any partial header in progress.
- R6: Valid bytes without `hdr_start` arriving while no header is open are ignored and produce no `hec_done`. The one exception is the check byte of R9.
- R7: `hec_byte` holds its value until the next header completes.
- R8: A new header may start in the same cycle that `hec_done` is high, with no lost cycle.
- R9: If `check_en` is high when the fourth byte is accepted, the next valid non-start byte is compared with the computed value. `hec_mismatch` then pulses for one cycle, in the cycle after that byte is accepted, only if the two differ.
- R10: If `check_en` is low when the fourth byte is accepted, no `hec_mismatch` pulse follows.
- R11: The lookup-table variant (USE_TABLE=1) and the shift variant (USE_TABLE=0) produce identical outputs for every input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Byte on `hdr_byte` is present this cycle |
| hdr_start | input | 1 | With `hdr_valid`: byte is the first of a header |
| hdr_byte | input | 8 | Header or received check byte |
| check_en | input | 1 | Arm comparison of the byte following the header |
| hec_byte | output | 8 | Computed check byte, held until the next completion |
| hec_done | output | 1 | One-cycle strobe: `hec_byte` just updated |
| hec_mismatch | output | 1 | One-cycle strobe: received check byte differed |

## Verification
A corrupted remainder or byte count in this block reaches the ports within one header. The next `hec_done` either appears on the wrong cycle or carries a wrong `hec_byte`, and both are visible one cycle after the fourth accepted byte. A stale check-armed flag shows up as a spurious or missing `hec_mismatch` one cycle after the following byte. The bench therefore compares all three outputs of both build variants on every clock against a behavioural model. That model computes the check byte by polynomial long division over the 40-bit padded header.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  // One bit-serial CRC step per input bit, MSB first: returns the remainder
  // after folding one byte into rem.
  function automatic logic [7:0] crc8_shift(input logic [7:0] rem,
                                            input logic [7:0] data,
                                            input logic [7:0] poly);
    logic [7:0] r;
    r = rem ^ data;
    for (int k = 0; k < 8; k++) begin
      if (r[7]) r = {r[6:0], 1'b0} ^ poly;
      else      r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  // Lookup-table entry for a given index (remainder XOR byte).
  function automatic logic [7:0] tbl_entry(input logic [7:0] idx,
                                           input logic [7:0] poly);
    return crc8_shift(8'h00, idx, poly);
  endfunction

endpackage

// File: rtl/hcs_step.sv
module hcs_step #(
  parameter logic [7:0] POLY      = 8'h07,
  parameter bit         USE_TABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rem_in,
  input  logic [7:0] byte_in,
  output logic [7:0] rem_out
);
  localparam int TBL_N = 256;

  logic [7:0] tbl_idx;
  assign tbl_idx = rem_in ^ byte_in;

  generate
    if (USE_TABLE) begin : g_table
      logic [7:0] tbl [TBL_N];
      for (genvar g = 0; g < TBL_N; g++) begin : g_fill
        assign tbl[g] = hcs_pkg::tbl_entry(8'(g), POLY);
      end
      assign rem_out = tbl[tbl_idx];

      // R11: the table path agrees with the bit-serial formulation
      a_r11_table_matches_shift: assert property (@(posedge clk) disable iff (!rst_n)
        rem_out == hcs_pkg::crc8_shift(rem_in, byte_in, POLY));
    end else begin : g_shift
      assign rem_out = hcs_pkg::crc8_shift(rem_in, 8'h00, POLY) ^
                       hcs_pkg::crc8_shift(8'h00, byte_in, POLY);
    end
  endgenerate

  // R11: a zero index always maps to a zero remainder in either variant
  a_r11_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_idx == 8'h00) |-> (rem_out == 8'h00));

endmodule

// File: rtl/hcs_seq.sv
module hcs_seq #(
  parameter int         NUM_BYTES = 4,
  parameter logic [7:0] POLY      = 8'h07,
  parameter logic [7:0] COSET     = 8'h55,
  parameter bit         USE_TABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_valid,
  input  logic       hdr_start,
  input  logic [7:0] hdr_byte,
  input  logic       check_en,
  output logic [7:0] result,
  output logic       done,
  output logic       fifth_acc
);
  localparam int                CNT_W    = $clog2(NUM_BYTES);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(NUM_BYTES - 1);
  localparam logic [CNT_W-1:0]  CNT_IDLE = '0;

  logic [CNT_W-1:0] cnt;
  logic [7:0]       rem;
  logic             chk_wait;

  // Named internal events
  logic       first_acc, more_acc, last_acc;
  logic [7:0] step_in, step_out;

  assign first_acc = hdr_valid && hdr_start;
  assign more_acc  = hdr_valid && !hdr_start && (cnt != CNT_IDLE);
  assign last_acc  = more_acc && (cnt == CNT_LAST);
  assign fifth_acc = hdr_valid && !hdr_start && (cnt == CNT_IDLE) && chk_wait;
  assign step_in   = first_acc ? 8'h00 : rem;

  hcs_step #(.POLY(POLY), .USE_TABLE(USE_TABLE)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .rem_in  (step_in),
    .byte_in (hdr_byte),
    .rem_out (step_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= CNT_IDLE;
      rem      <= 8'h00;
      chk_wait <= 1'b0;
      result   <= 8'h00;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (first_acc) begin
        rem      <= step_out;
        cnt      <= CNT_W'(1);
        chk_wait <= 1'b0;
      end else if (last_acc) begin
        result   <= step_out ^ COSET;
        done     <= 1'b1;
        cnt      <= CNT_IDLE;
        chk_wait <= check_en;
      end else if (more_acc) begin
        rem <= step_out;
        cnt <= cnt + CNT_W'(1);
      end else if (fifth_acc) begin
        chk_wait <= 1'b0;
      end
    end
  end

  // R3: completion strobe lasts one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: completion follows an accepted byte
  a_r3_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(hdr_valid));
  // R6: a completing byte never carries a start flag
  a_r6_done_not_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(hdr_start));
  // R7: the result moves only when a completion is signalled
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R5: a start byte always leaves exactly one byte counted
  a_r5_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    first_acc |=> (cnt == CNT_W'(1)));
  // R4: no valid byte, no change to the running state
  a_r4_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(rem) && $stable(cnt)));

endmodule

// File: rtl/hcs_check.sv
module hcs_check (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifth_acc,
  input  logic [7:0] rx_byte,
  input  logic [7:0] computed,
  output logic       mismatch
);
  logic differs;
  assign differs = (rx_byte != computed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mismatch <= 1'b0;
    else        mismatch <= fifth_acc && differs;
  end

  // R9: mismatch strobe lasts a single cycle
  a_r9_mismatch_single: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> !mismatch);
  // R10: a mismatch needs an armed comparison byte one cycle earlier
  a_r10_mismatch_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> $past(fifth_acc));

endmodule

// File: rtl/hcs_gen.sv
module hcs_gen #(
  parameter int         NUM_BYTES = 4,
  parameter logic [7:0] POLY      = 8'h07,
  parameter logic [7:0] COSET     = 8'h55,
  parameter bit         USE_TABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_valid,
  input  logic       hdr_start,
  input  logic [7:0] hdr_byte,
  input  logic       check_en,
  output logic [7:0] hec_byte,
  output logic       hec_done,
  output logic       hec_mismatch
);
  logic fifth_acc;

  hcs_seq #(
    .NUM_BYTES (NUM_BYTES),
    .POLY      (POLY),
    .COSET     (COSET),
    .USE_TABLE (USE_TABLE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_start (hdr_start),
    .hdr_byte  (hdr_byte),
    .check_en  (check_en),
    .result    (hec_byte),
    .done      (hec_done),
    .fifth_acc (fifth_acc)
  );

  hcs_check u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifth_acc (fifth_acc),
    .rx_byte   (hdr_byte),
    .computed  (hec_byte),
    .mismatch  (hec_mismatch)
  );

  // R1: outputs quiet right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    ($rose(rst_n)) |-> (!hec_done && !hec_mismatch));
  // R9: done and mismatch never coincide
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hec_done && hec_mismatch));

endmodule

// File: tb/hcs_gen_tb_top.sv
module hcs_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, hdr_start = 1'b0, check_en = 1'b0;
  logic [7:0] hdr_byte = 8'h00;

  logic [7:0] out_t, out_s;
  logic done_t, done_s, mis_t, mis_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcs_gen #(.USE_TABLE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_start(hdr_start),
    .hdr_byte(hdr_byte), .check_en(check_en),
    .hec_byte(out_t), .hec_done(done_t), .hec_mismatch(mis_t));

  hcs_gen #(.USE_TABLE(1'b0)) dut_s (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_start(hdr_start),
    .hdr_byte(hdr_byte), .check_en(check_en),
    .hec_byte(out_s), .hec_done(done_s), .hec_mismatch(mis_s));

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  // Long division of header * x^8 by x^8+x^2+x+1, then the 0x55 coset.
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] m;
    m = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (m[i]) m[i -: 9] = m[i -: 9] ^ 9'h107;
    return m[7:0] ^ 8'h55;
  endfunction

  // Behavioural reference
  logic [7:0] exp_out = 8'h00;
  logic exp_done = 1'b0, exp_mis = 1'b0;
  logic [7:0] q[$];
  bit armed = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_out <= 8'h00; exp_done <= 1'b0; exp_mis <= 1'b0;
      q.delete(); armed = 1'b0;
    end else begin
      exp_done <= 1'b0;
      exp_mis  <= 1'b0;
      if (hdr_valid) begin
        if (hdr_start) begin
          q.delete(); q.push_back(hdr_byte); armed = 1'b0;
        end else if (q.size() > 0) begin
          q.push_back(hdr_byte);
          if (q.size() == 4) begin
            exp_out  <= ref_hec({q[0], q[1], q[2], q[3]});
            exp_done <= 1'b1;
            armed = check_en;
            q.delete();
          end
        end else if (armed) begin
          exp_mis <= (hdr_byte != exp_out);
          armed = 1'b0;
        end
      end
    end
  end

  // Per-cycle comparison of both variants (R11 covers their agreement)
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (out_t !== exp_out || done_t !== exp_done || mis_t !== exp_mis) begin
        n_bad++;
        $display("FAIL %s table: out=%h done=%b mis=%b exp out=%h done=%b mis=%b",
                 phase, out_t, done_t, mis_t, exp_out, exp_done, exp_mis);
      end
      n_cmp++;
      if (out_s !== out_t || done_s !== done_t || mis_s !== mis_t) begin
        n_bad++;
        $display("FAIL R11 shift: out=%h done=%b mis=%b exp out=%h done=%b mis=%b",
                 out_s, done_s, mis_s, out_t, done_t, mis_t);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic s, input logic [7:0] d);
    hdr_valid = v; hdr_start = s; hdr_byte = d;
    @(negedge clk);
    hdr_valid = 1'b0; hdr_start = 1'b0;
  endtask

  task automatic send_hdr(input logic [31:0] h);
    put(1'b1, 1'b1, h[31:24]);
    put(1'b1, 1'b0, h[23:16]);
    put(1'b1, 1'b0, h[15:8]);
    put(1'b1, 1'b0, h[7:0]);
  endtask

  bit finished = 1'b0;

  initial begin
    @(negedge clk);
    check("R1 reset out", {23'd0, out_t, done_t}, 32'd0);
    check("R1 reset mis", {31'd0, mis_t}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {22'd0, out_t, done_t, mis_t}, 32'd0);

    phase = "R2";
    send_hdr(32'h0000_0000);
    check("R2 zero header", {24'd0, out_t}, 32'h55);
    check("R3 done on cycle after 4th", {31'd0, done_t}, 32'd1);
    @(negedge clk);
    check("R3 done drops", {31'd0, done_t}, 32'd0);
    send_hdr(32'h0000_0001);
    check("R2 one header", {24'd0, out_t}, 32'h52);
    for (int k = 0; k < 40; k++) begin
      logic [31:0] h;
      h = $urandom;
      send_hdr(h);
      check("R2 random header", {24'd0, out_t}, {24'd0, ref_hec(h)});
    end

    phase = "R4";
    for (int k = 0; k < 20; k++) begin
      logic [31:0] h;
      h = $urandom;
      for (int b = 3; b >= 0; b--) begin
        put(1'b1, b == 3, h[b*8 +: 8]);
        if (b != 0) repeat ($urandom_range(0, 3)) put(1'b0, 1'b0, $urandom);
      end
      check("R4 gapped header", {24'd0, out_t}, {24'd0, ref_hec(h)});
    end

    phase = "R5";
    put(1'b1, 1'b1, 8'hAA); put(1'b1, 1'b0, 8'hBB);
    send_hdr(32'h1234_5678);
    check("R5 restart mid header", {24'd0, out_t}, {24'd0, ref_hec(32'h1234_5678)});

    phase = "R6";
    repeat (6) put(1'b1, 1'b0, 8'hC3);
    check("R6 orphan bytes no done", {31'd0, done_t}, 32'd0);

    phase = "R7";
    repeat (5) put(1'b0, 1'b0, 8'h00);
    check("R7 result held", {24'd0, out_t}, {24'd0, ref_hec(32'h1234_5678)});

    phase = "R8";
    for (int k = 0; k < 10; k++) send_hdr(32'hF0E1_D2C3 + k);
    check("R8 back to back", {24'd0, out_t}, {24'd0, ref_hec(32'hF0E1_D2C3 + 9)});

    phase = "R9";
    check_en = 1'b1;
    send_hdr(32'hDEAD_BEEF);
    put(1'b1, 1'b0, ref_hec(32'hDEAD_BEEF) ^ 8'h01);
    check("R9 mismatch pulse", {31'd0, mis_t}, 32'd1);
    @(negedge clk);
    check("R9 mismatch drops", {31'd0, mis_t}, 32'd0);
    send_hdr(32'hCAFE_0042);
    put(1'b1, 1'b0, ref_hec(32'hCAFE_0042));
    check("R9 match no pulse", {31'd0, mis_t}, 32'd0);
    for (int k = 0; k < 20; k++) begin
      logic [31:0] h;
      h = $urandom;
      send_hdr(h);
      repeat ($urandom_range(0, 2)) put(1'b0, 1'b0, 8'h00);
      put(1'b1, 1'b0, (k % 2 == 0) ? ref_hec(h) : $urandom);
    end

    phase = "R10";
    check_en = 1'b0;
    send_hdr(32'h0BAD_F00D);
    put(1'b1, 1'b0, ~ref_hec(32'h0BAD_F00D));
    check("R10 disarmed no pulse", {31'd0, mis_t}, 32'd0);

    phase = "R11";
    for (int k = 0; k < 300; k++) begin
      check_en = $urandom_range(0, 1);
      put($urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0, $urandom);
    end
    check("R11 variants agree", {24'd0, out_s}, {24'd0, out_t});

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule